// File: doc/BRIEF.md
# Serial EEPROM Read Target with Protection Status Query

This block is the read side of a two-wire serial EEPROM target. It watches the clock and data lines and finds START, repeated START and STOP conditions. It decodes the first byte of each transfer. It keeps an internal byte pointer that survives from one transfer to the next, and it serves three kinds of read: current-address reads, sequential reads and selective reads. A selective read first loads the pointer through a write header with no data byte.

A second family of header bytes asks about the write-protection state. These bytes carry the protection device type and a set R/W bit. The block answers them with ACK or NACK only, according to the permanent and reversible protection inputs. Every byte that follows a query is refused.

The data line is open-drain: the block reads `sda_in` and pulls the line low through `sda_drive_low`. It changes `sda_drive_low` only while the synchronised SCL is low. The storage sits outside the block, behind a synchronous read port whose data is valid one cycle after the request.

Top module: `i2c_eeprom_reader`

## Requirements
- R1: After reset, `sda_drive_low` is 0 and the byte pointer is 0, so the first current-address read returns the byte at location 0.
- R2: A header byte of device type 1010 (bits 7:4), pin-select bits 3:1 equal to `strap_sel`, and bit 0 = 1 gets ACK in the ninth clock. The block then drives the byte at the pointer, MSB first, and raises `sda_drive_low` only while SCL is low.
- R3: A header byte whose bits 3:1 differ from `strap_sel` gets no ACK, and SDA stays released for the rest of that transfer.
- R4: While the master ACKs, each following byte comes from the next location. The pointer keeps the address after the last byte sent, so a later transfer continues from there.
- R5: After location 2^ADDR_W-1 the pointer wraps, and the next byte read comes from location 0.
- R6: A selective read works as follows. A write header (bit 0 = 0) and a byte-address byte both get ACK. A repeated START and a read header then return the byte at that address.
- R7: When the master answers a data byte with NACK, the block releases SDA and sends no more data. After a STOP, `sda_drive_low` is 0.
- R8: When `prot_perm` is 1, each protection query gets NACK. A query is device type 0110, bit 0 = 1, and bits 3:1 = 001 (reversible), 011 (clear reversible) or 010 (permanent).
- R9: When neither protection input is set, all three queries get ACK.
- R10: When only `prot_rev` is set, the reversible query (001) gets NACK, and the clear-reversible (011) and permanent (010) queries get ACK.
- R11: The two bytes that follow an acknowledged query both get NACK, and the byte pointer is left unchanged.
- R12: A STOP or a repeated START in the middle of a byte aborts the transfer, and the byte pointer keeps its value.
- R13: A data byte sent after the byte address of a write header gets NACK, and the pointer keeps the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line (asynchronous) |
| sda_in | input | 1 | Serial data line as seen on the wire |
| sda_drive_low | output | 1 | Pulls the data line low when 1 |
| strap_sel | input | 3 | Board strap compared with header bits 3:1 |
| mem_rd_en | output | 1 | One-cycle read request to storage |
| mem_rd_addr | output | ADDR_W | Read address to storage |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| prot_perm | input | 1 | Permanent write protection is in force |
| prot_rev | input | 1 | Reversible write protection is in force |

## Verification
The hardest state to reach from the ports is a transfer cut off in the middle of a byte. The master has to raise or lower SDA while SCL is high after only a few bits, and the target must not be driving the line at that moment. The stimulus therefore aborts during a write header's byte-address phase, where the master owns the line. It first loads the pointer to a known value and then uses both STOP and repeated START to cut the byte short. A current-address read afterwards shows that the pointer did not move. Pointer wrap is reached by selecting location 2^ADDR_W-2 and reading three bytes in sequence.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_PRE_ACK, ST_ACK, ST_TX, ST_MACK, ST_MACK_DONE, ST_IGNORE
  } eng_state_t;

  typedef enum logic [1:0] {NX_WORD, NX_TX, NX_IGN} next_act_t;
  typedef enum logic {RX_DEV, RX_WORD} rx_kind_t;

  localparam logic [3:0] MEM_TYPE  = 4'b1010;
  localparam logic [3:0] PROT_TYPE = 4'b0110;
  localparam logic [2:0] Q_REV     = 3'b001;
  localparam logic [2:0] Q_CLR     = 3'b011;
  localparam logic [2:0] Q_PERM    = 3'b010;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_p    <= scl_pipe[STAGES-1];
      sda_p    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_addr_ctr.sv
module i2c_addr_ctr #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2c_prot_query.sv
module i2c_prot_query
  import i2c_rd_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       perm,
  input  logic       rev,
  output logic       known,
  output logic       ack
);
  always_comb begin
    known = (sel == Q_REV) || (sel == Q_CLR) || (sel == Q_PERM);
    if (perm)                    ack = 1'b0;
    else if (rev && sel == Q_REV) ack = 1'b0;
    else                          ack = 1'b1;
  end
endmodule

// File: rtl/i2c_eeprom_reader.sv
module i2c_eeprom_reader
  import i2c_rd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_drive_low,
  input  logic [2:0]        strap_sel,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  input  logic              prot_perm,
  input  logic              prot_rev
);
  localparam int BYTE_W = 8;
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);
  localparam logic [3:0] ALL_BITS = 4'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eng_state_t        state;
  rx_kind_t          kind;
  next_act_t         nxt;
  logic [3:0]        bitcnt;
  logic [6:0]        rx_sh;
  logic [6:0]        tx_sh;
  logic [7:0]        tx_buf;
  logic              sda_low, rd_en, fetch_d1;
  logic [ADDR_W-1:0] rd_addr, rd_ptr;
  logic [7:0]        rx_byte;
  logic              byte_done, dev_is_mem, dev_is_query, q_known, q_ack;
  logic              ctr_load, ctr_inc;

  assign rx_byte      = {rx_sh, sda_s};
  assign byte_done    = (state == ST_RX) && scl_rise && (bitcnt == LAST_BIT);
  assign dev_is_mem   = (rx_byte[7:4] == MEM_TYPE) && (rx_byte[3:1] == strap_sel);
  assign dev_is_query = (rx_byte[7:4] == PROT_TYPE) && rx_byte[0];
  assign ctr_load     = byte_done && (kind == RX_WORD);
  assign ctr_inc      = (state == ST_TX) && scl_fall && (bitcnt == ALL_BITS);

  i2c_prot_query u_query (
    .sel(rx_byte[3:1]), .perm(prot_perm), .rev(prot_rev),
    .known(q_known), .ack(q_ack)
  );

  i2c_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk(clk), .rst(rst), .load(ctr_load),
    .load_val(rx_byte[ADDR_W-1:0]), .inc(ctr_inc), .cnt(rd_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      kind    <= RX_DEV;
      nxt     <= NX_IGN;
      bitcnt  <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      sda_low <= 1'b0;
      rd_en   <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_en <= 1'b0;
      if (stop_det) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (start_det) begin
        state   <= ST_RX;
        kind    <= RX_DEV;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            rx_sh  <= rx_byte[6:0];
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) begin
              if (kind == RX_WORD) begin
                nxt   <= NX_IGN;
                state <= ST_PRE_ACK;
              end else if (dev_is_mem) begin
                state <= ST_PRE_ACK;
                if (rx_byte[0]) begin
                  nxt     <= NX_TX;
                  rd_en   <= 1'b1;
                  rd_addr <= rd_ptr;
                end else begin
                  nxt <= NX_WORD;
                end
              end else if (dev_is_query && q_known && q_ack) begin
                nxt   <= NX_IGN;
                state <= ST_PRE_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          ST_PRE_ACK: if (scl_fall) begin
            sda_low <= 1'b1;
            state   <= ST_ACK;
          end
          ST_ACK: if (scl_fall) begin
            case (nxt)
              NX_WORD: begin
                sda_low <= 1'b0;
                kind    <= RX_WORD;
                bitcnt  <= '0;
                state   <= ST_RX;
              end
              NX_TX: begin
                tx_sh   <= tx_buf[6:0];
                sda_low <= ~tx_buf[7];
                bitcnt  <= 4'd1;
                state   <= ST_TX;
              end
              default: begin
                sda_low <= 1'b0;
                state   <= ST_IGNORE;
              end
            endcase
          end
          ST_TX: if (scl_fall) begin
            if (bitcnt == ALL_BITS) begin
              sda_low <= 1'b0;
              state   <= ST_MACK;
            end else begin
              sda_low <= ~tx_sh[6];
              tx_sh   <= {tx_sh[5:0], 1'b0};
              bitcnt  <= bitcnt + 1'b1;
            end
          end
          ST_MACK: if (scl_rise) begin
            if (!sda_s) begin
              rd_en   <= 1'b1;
              rd_addr <= rd_ptr;
              state   <= ST_MACK_DONE;
            end else begin
              state <= ST_IGNORE;
            end
          end
          ST_MACK_DONE: if (scl_fall) begin
            tx_sh   <= tx_buf[6:0];
            sda_low <= ~tx_buf[7];
            bitcnt  <= 4'd1;
            state   <= ST_TX;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_d1 <= 1'b0;
      tx_buf   <= '0;
    end else begin
      fetch_d1 <= rd_en;
      if (fetch_d1) tx_buf <= mem_rd_data;
    end
  end

  assign sda_drive_low = sda_low;
  assign mem_rd_en     = rd_en;
  assign mem_rd_addr   = rd_addr;
endmodule

// File: rtl/i2c_eeprom_reader_chk.sv
module i2c_eeprom_reader_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input logic              sda_drive_low,
  input logic              mem_rd_en,
  input logic              ctr_load,
  input logic [ADDR_W-1:0] rd_ptr
);
  p_sda_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !scl_s);

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  p_stop_release_r7: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_drive_low);

  p_abort_keep_r12: assert property (@(posedge clk) disable iff (rst)
    (start_det || stop_det) |=> (rd_ptr == $past(rd_ptr)));

  p_ptr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_ptr != $past(rd_ptr)) |->
      ($past(ctr_load) || rd_ptr == ADDR_W'($past(rd_ptr) + 1'b1)));

  p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (($past(rd_ptr) == '1) && !$past(ctr_load) && (rd_ptr != $past(rd_ptr)))
      |-> (rd_ptr == '0));
endmodule

bind i2c_eeprom_reader i2c_eeprom_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_drive_low(sda_drive_low), .mem_rd_en(mem_rd_en),
  .ctr_load(ctr_load), .rd_ptr(rd_ptr)
);

// File: tb/i2c_eeprom_reader_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_reader_bench;
  localparam int ADDR_W = 8;
  localparam int H = 10;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] HDR_RD = {4'b1010, STRAP, 1'b1};
  localparam logic [7:0] HDR_WR = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] HDR_BAD = {4'b1010, 3'b100, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic sda_bus, sda_drive_low, mem_rd_en, prot_perm, prot_rev;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [7:0] mem_rd_data;
  int checks = 0;
  int errors = 0;
  int exp_ptr = 0;

  always #5 clk = ~clk;

  assign sda_bus = ~(m_low | sda_drive_low);

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 7) + 60);
  endfunction

  always_ff @(posedge clk) if (mem_rd_en) mem_rd_data <= mval(int'(mem_rd_addr));

  i2c_eeprom_reader #(.ADDR_W(ADDR_W)) u_i2c_eeprom_reader (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_bus),
    .sda_drive_low(sda_drive_low), .strap_sel(STRAP),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .prot_perm(prot_perm), .prot_rev(prot_rev)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    if (!scl) begin
      w(2); m_low = 1'b0; w(H); scl = 1'b1; w(H);
    end
    m_low = 1'b1; w(H); scl = 1'b0;
  endtask

  task automatic bus_stop();
    w(2); m_low = 1'b1; w(H); scl = 1'b1; w(H); m_low = 1'b0; w(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      w(2); m_low = ~b[i]; w(H - 2); scl = 1'b1; w(H); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    send_bits(b, 8);
    w(2); m_low = 1'b0; w(H - 2); scl = 1'b1; w(H / 2);
    acked = (sda_bus == 1'b0);
    w(H / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mack);
    for (int i = 7; i >= 0; i--) begin
      w(2); m_low = 1'b0; w(H - 2); scl = 1'b1; w(H / 2);
      b[i] = sda_bus;
      w(H / 2); scl = 1'b0;
    end
    w(2); m_low = mack; w(H - 2); scl = 1'b1; w(H); scl = 1'b0;
    w(2); m_low = 1'b0;
  endtask

  task automatic read_one(input string req);
    logic a; logic [7:0] d;
    bus_start(); send_byte(HDR_RD, a);
    chk({req, " header ack"}, int'(a), 1);
    recv_byte(d, 1'b0); bus_stop();
    chk({req, " data"}, int'(d), int'(mval(exp_ptr)));
    exp_ptr = (exp_ptr + 1) % 256;
  endtask

  task automatic t_reset();
    chk("R1 sda released after reset", int'(sda_drive_low), 0);
    read_one("R1 R2 first read from location 0");
  endtask

  task automatic t_strap();
    logic a; logic [7:0] d;
    bus_start(); send_byte(HDR_BAD, a);
    chk("R3 mismatched strap no ack", int'(a), 0);
    recv_byte(d, 1'b1);
    chk("R3 line released", int'(d), 8'hFF);
    bus_stop();
  endtask

  task automatic t_sequential();
    logic a; logic [7:0] d;
    bus_start(); send_byte(HDR_RD, a);
    chk("R4 header ack", int'(a), 1);
    for (int k = 0; k < 3; k++) begin
      recv_byte(d, k < 2);
      chk("R4 sequential byte", int'(d), int'(mval(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % 256;
    end
    w(4);
    chk("R7 released after master nack", int'(sda_drive_low), 0);
    bus_stop(); w(20);
    chk("R7 released after stop", int'(sda_drive_low), 0);
    read_one("R4 pointer persists");
  endtask

  task automatic t_selective_wrap();
    logic a; logic [7:0] d;
    bus_start(); send_byte(HDR_WR, a);
    chk("R6 write header ack", int'(a), 1);
    send_byte(8'hFE, a);
    chk("R6 byte address ack", int'(a), 1);
    bus_start(); send_byte(HDR_RD, a);
    chk("R6 read header ack", int'(a), 1);
    exp_ptr = 8'hFE;
    for (int k = 0; k < 3; k++) begin
      recv_byte(d, k < 2);
      chk("R5 R6 byte across wrap", int'(d), int'(mval(exp_ptr)));
      exp_ptr = (exp_ptr + 1) % 256;
    end
    bus_stop();
  endtask

  task automatic t_data_nack();
    logic a;
    bus_start(); send_byte(HDR_WR, a); send_byte(8'h10, a);
    send_byte(8'h99, a);
    chk("R13 data byte nack", int'(a), 0);
    bus_stop();
    exp_ptr = 8'h10;
    read_one("R13 pointer keeps loaded address");
  endtask

  task automatic t_queries();
    logic a;
    logic [2:0] codes [3];
    codes[0] = 3'b001; codes[1] = 3'b011; codes[2] = 3'b010;
    for (int s = 0; s < 4; s++) begin
      prot_perm = (s == 0) || (s == 3);
      prot_rev  = (s == 2) || (s == 3);
      for (int c = 0; c < 3; c++) begin
        int exp_ack;
        string req;
        if (prot_perm) begin exp_ack = 0; req = "R8 perm query"; end
        else if (prot_rev) begin exp_ack = (c == 0) ? 0 : 1; req = "R10 rev query"; end
        else begin exp_ack = 1; req = "R9 open query"; end
        bus_start(); send_byte({4'b0110, codes[c], 1'b1}, a);
        chk(req, int'(a), exp_ack);
        if (exp_ack == 1) begin
          send_byte(8'h00, a);
          chk("R11 byte after query nack", int'(a), 0);
          send_byte(8'h00, a);
          chk("R11 data after query nack", int'(a), 0);
        end
        bus_stop();
      end
    end
    prot_perm = 1'b0; prot_rev = 1'b0;
    read_one("R11 pointer unchanged by queries");
  endtask

  task automatic t_abort();
    logic a; logic [7:0] d;
    bus_start(); send_byte(HDR_WR, a);
    send_bits(8'h00, 4);
    bus_stop();
    read_one("R12 stop mid-byte keeps pointer");
    bus_start(); send_byte(HDR_WR, a);
    send_bits(8'hFF, 3);
    bus_start(); send_byte(HDR_RD, a);
    chk("R12 header after restart ack", int'(a), 1);
    recv_byte(d, 1'b1); bus_stop();
    chk("R12 restart mid-byte keeps pointer", int'(d), int'(mval(exp_ptr)));
    exp_ptr = (exp_ptr + 1) % 256;
  endtask

  initial begin
    prot_perm = 1'b0; prot_rev = 1'b0;
    w(5); rst = 1'b0; w(5);
    t_reset();
    t_strap();
    t_sequential();
    t_selective_wrap();
    t_data_nack();
    t_queries();
    t_abort();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule